// File: doc/BRIEF.md
# Immediate Escape and Branch Decoder

This block decodes the immediate part of a fetched instruction for a small co-processor. The instruction carries a 15-bit signed immediate. For the immediate-operand opcode, two reserved values of that field mean that a wide constant sits inline right after the instruction word, either 32 or 64 bits long. No separate opcodes for wide constants are needed. The block turns the field into a 64-bit operand and works out where the next instruction begins, skipping over any inline constant.

The same field also serves as a signed word offset for branches that are relative to the instruction pointer. The block computes the branch target on a 20-bit byte address, which covers one megabyte. It also applies the single decrement of the decrement-and-jump instruction to a loop register value. The fetch stage presents the current IP, the instruction word, the two 32-bit words that follow it and the loop register, with a valid strobe. One cycle later the block presents the registered results.

The instruction layout is as follows. The opcode sits in bits [31:26] and the immediate in bits [14:0]. Opcode 6'h01 is the immediate operand op, 6'h02 is the unconditional relative branch and 6'h03 is decrement-and-jump. Every other opcode is treated as a plain op.

Top module: `imm_branch_decoder`

## Requirements
- R1: While reset is held low and after its release, until the first valid input: outValid, taken and loopWrite are 0, and operand, nextIp, branchTarget and loopOut are all zero.
- R2: outValid is high exactly in the cycle after a cycle with inValid high. Inputs presented with inValid low do not change any result output.
- R3: For opcode 6'h01 with an immediate other than 15'h4000 and 15'h4001, the operand is the immediate sign-extended from bit 14 to 64 bits, so 25000 reads as a negative value. nextIp is IP+4.
- R4: For opcode 6'h01 with immediate 15'h4001, the operand is extWord0 (the word at IP+4) sign-extended to 64 bits, and nextIp is IP+8.
- R5: For opcode 6'h01 with immediate 15'h4000, the operand is {extWord1, extWord0}, with the low word at IP+4 and the high word at IP+8. nextIp is IP+12.
- R6: For opcode 6'h02, branchTarget is IP plus four times the sign-extended immediate, modulo 2^20. taken is 1 and nextIp equals branchTarget. The immediate values 15'h4000 and 15'h4001 carry no special meaning here.
- R7: For opcode 6'h03, loopOut is loopIn minus exactly one (modulo 2^64) and loopWrite is 1. taken is 1 if and only if loopOut is non-zero. nextIp is branchTarget when taken and IP+4 otherwise.
- R8: For any other opcode, the operand is the sign-extended immediate, nextIp is IP+4, taken and loopWrite are 0, and loopOut equals loopIn. The escape values are not treated as escapes.
- R9: All IP arithmetic wraps modulo 2^20. For example, IP 20'hFFFF8 with a 64-bit inline constant gives nextIp 20'h00004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Fetch bundle on the inputs is valid this cycle |
| curIp | input | 20 | Byte address of the instruction |
| instrWord | input | 32 | Instruction word |
| extWord0 | input | 32 | Word at curIp+4 |
| extWord1 | input | 32 | Word at curIp+8 |
| loopIn | input | 64 | Current loop register value |
| outValid | output | 1 | Results below belong to the last valid input |
| operand | output | 64 | Decoded 64-bit operand |
| nextIp | output | 20 | Address of the next instruction to fetch |
| branchTarget | output | 20 | IP-relative branch target |
| loopOut | output | 64 | New loop register value |
| loopWrite | output | 1 | Loop register is to be written |
| taken | output | 1 | Control transfer to branchTarget |

## Verification
The bench builds the block with its default parameters: a 20-bit IP, 64-bit data and a 15-bit immediate. At these values, IP 20'hFFFF8 brings the wrap of the 12-byte step and of negative offsets within reach. The full 15-bit field reaches both escape codes and the negative reading of 25000. The loop register reaches the zero-to-all-ones underflow of decrement-and-jump. Each table entry checks the operand, both addresses, the loop result and the flags together, so a shifted escape code or a double decrement shows up at the ports.

// File: rtl/imm_dec_pkg.sv
package imm_dec_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_IMM  = 6'h01;
  localparam logic [OPC_W-1:0] OPC_BR   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_LOOP = 6'h03;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic selExt32;
    logic selExt64;
    logic isBranch;
    logic isLoop;
  } decCtl_t;
endpackage

// File: rtl/imm_dec_ctrl.sv
module imm_dec_ctrl
  import imm_dec_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IMM_W = 15,
  parameter logic [IMM_W-1:0] ESC32 = 15'h4001,
  parameter logic [IMM_W-1:0] ESC64 = 15'h4000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output decCtl_t            ctl,
  output logic               outValid
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] immField;

  assign opc      = instrWord[INSTR_W-1:OPC_LSB];
  assign immField = instrWord[IMM_W-1:0];

  always_comb begin
    ctl = '0;
    ctl.capture = inValid;
    unique case (opc)
      OPC_IMM: begin
        ctl.selExt32 = (immField == ESC32);
        ctl.selExt64 = (immField == ESC64);
      end
      OPC_BR:   ctl.isBranch = 1'b1;
      OPC_LOOP: ctl.isLoop = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selExt32, ctl.selExt64, ctl.isBranch, ctl.isLoop}));
endmodule

// File: rtl/imm_dec_datapath.sv
module imm_dec_datapath
  import imm_dec_pkg::*;
#(
  parameter int IP_W = 20,
  parameter int DATA_W = 64,
  parameter int INSTR_W = 32,
  parameter int IMM_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  decCtl_t            ctl,
  input  logic [IP_W-1:0]    curIp,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [INSTR_W-1:0] extWord0,
  input  logic [INSTR_W-1:0] extWord1,
  input  logic [DATA_W-1:0]  loopIn,
  output logic [DATA_W-1:0]  operand,
  output logic [IP_W-1:0]    nextIp,
  output logic [IP_W-1:0]    branchTarget,
  output logic [DATA_W-1:0]  loopOut,
  output logic               loopWrite,
  output logic               taken
);
  localparam int WORD_B = INSTR_W / 8;
  localparam int OFS_PAD = IP_W - IMM_W - 2;
  localparam logic [IP_W-1:0] STEP1 = IP_W'(WORD_B);
  localparam logic [IP_W-1:0] STEP2 = IP_W'(2 * WORD_B);
  localparam logic [IP_W-1:0] STEP3 = IP_W'(3 * WORD_B);

  logic [IMM_W-1:0]  immField;
  logic [DATA_W-1:0] immSext, ext32Sext, ext64Val, opNext;
  logic [IP_W-1:0]   relOfs, tgtNext, seqNext, ipNext;
  logic [DATA_W-1:0] loopDec, loopNext;
  logic              takeNext;

  assign immField  = instrWord[IMM_W-1:0];
  assign immSext   = {{(DATA_W-IMM_W){immField[IMM_W-1]}}, immField};
  assign ext32Sext = {{(DATA_W-INSTR_W){extWord0[INSTR_W-1]}}, extWord0};
  assign ext64Val  = {extWord1, extWord0};
  assign relOfs    = {{OFS_PAD{immField[IMM_W-1]}}, immField, 2'b00};
  assign tgtNext   = curIp + relOfs;
  assign loopDec   = loopIn - 1'b1;

  always_comb begin
    if (ctl.selExt64)      opNext = ext64Val;
    else if (ctl.selExt32) opNext = ext32Sext;
    else                   opNext = immSext;
  end

  always_comb begin
    if (ctl.selExt64)      seqNext = curIp + STEP3;
    else if (ctl.selExt32) seqNext = curIp + STEP2;
    else                   seqNext = curIp + STEP1;
  end

  always_comb begin
    takeNext = ctl.isBranch | (ctl.isLoop & (loopDec != '0));
    loopNext = ctl.isLoop ? loopDec : loopIn;
    ipNext   = takeNext ? tgtNext : seqNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operand      <= '0;
      nextIp       <= '0;
      branchTarget <= '0;
      loopOut      <= '0;
      loopWrite    <= 1'b0;
      taken        <= 1'b0;
    end else if (ctl.capture) begin
      operand      <= opNext;
      nextIp       <= ipNext;
      branchTarget <= tgtNext;
      loopOut      <= loopNext;
      loopWrite    <= ctl.isLoop;
      taken        <= takeNext;
    end
  end

  // R7
  loop_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.isLoop) |=> (loopWrite && loopOut == $past(loopIn) - 1'b1));
  // R8
  loop_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.isLoop) |=> (!loopWrite && loopOut == $past(loopIn)));
  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.isBranch && !ctl.isLoop) |=>
      (nextIp == $past(curIp) + STEP1 || nextIp == $past(curIp) + STEP2 ||
       nextIp == $past(curIp) + STEP3));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(operand) && $stable(nextIp) && $stable(loopOut)));
  // R6
  branch_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.isBranch) |=> (taken && nextIp == branchTarget));
endmodule

// File: rtl/imm_branch_decoder.sv
module imm_branch_decoder
  import imm_dec_pkg::*;
#(
  parameter int IP_W = 20,
  parameter int DATA_W = 64,
  parameter int INSTR_W = 32,
  parameter int IMM_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [IP_W-1:0]    curIp,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [INSTR_W-1:0] extWord0,
  input  logic [INSTR_W-1:0] extWord1,
  input  logic [DATA_W-1:0]  loopIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  operand,
  output logic [IP_W-1:0]    nextIp,
  output logic [IP_W-1:0]    branchTarget,
  output logic [DATA_W-1:0]  loopOut,
  output logic               loopWrite,
  output logic               taken
);
  decCtl_t ctl;

  imm_dec_ctrl #(.INSTR_W(INSTR_W), .IMM_W(IMM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .ctl(ctl), .outValid(outValid)
  );

  imm_dec_datapath #(.IP_W(IP_W), .DATA_W(DATA_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curIp(curIp), .instrWord(instrWord),
    .extWord0(extWord0), .extWord1(extWord1), .loopIn(loopIn),
    .operand(operand), .nextIp(nextIp), .branchTarget(branchTarget),
    .loopOut(loopOut), .loopWrite(loopWrite), .taken(taken)
  );
endmodule

// File: tb/tb_imm_branch_decoder.sv
module tb_imm_branch_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [19:0] curIp = '0;
  logic [31:0] instrWord = '0, extWord0 = '0, extWord1 = '0;
  logic [63:0] loopIn = '0;
  logic        outValid, loopWrite, taken;
  logic [63:0] operand, loopOut;
  logic [19:0] nextIp, branchTarget;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  imm_branch_decoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .curIp(curIp), .instrWord(instrWord),
    .extWord0(extWord0), .extWord1(extWord1), .loopIn(loopIn), .outValid(outValid),
    .operand(operand), .nextIp(nextIp), .branchTarget(branchTarget),
    .loopOut(loopOut), .loopWrite(loopWrite), .taken(taken)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [19:0] ip;
    logic [31:0] instr;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [63:0] lin;
    logic [63:0] expOp;
    logic [19:0] expNext;
    logic [19:0] expTgt;
    logic [63:0] expLoop;
    logic        expWe;
    logic        expTaken;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3 small positive immediate
    '{4'd3, 20'h00100, 32'h04000005, 32'h0, 32'h0, 64'd7, 64'd5, 20'h00104, 20'h00114, 64'd7, 1'b0, 1'b0},
    // R3 25000 reads negative
    '{4'd3, 20'h00200, 32'h040061A8, 32'h0, 32'h0, 64'd7, 64'hFFFF_FFFF_FFFF_E1A8, 20'h00204, 20'hF88A0, 64'd7, 1'b0, 1'b0},
    // R4 32-bit constant, negative
    '{4'd4, 20'h00300, 32'h04004001, 32'h8000_0001, 32'h5555_5555, 64'd1, 64'hFFFF_FFFF_8000_0001, 20'h00308, 20'hF0304, 64'd1, 1'b0, 1'b0},
    // R4 32-bit constant, positive
    '{4'd4, 20'h00400, 32'h04004001, 32'h1234_5678, 32'hFFFF_FFFF, 64'd2, 64'h0000_0000_1234_5678, 20'h00408, 20'hF0404, 64'd2, 1'b0, 1'b0},
    // R5 64-bit constant, low word first
    '{4'd5, 20'h00500, 32'h04004000, 32'hDEAD_BEEF, 32'h0123_4567, 64'd3, 64'h0123_4567_DEAD_BEEF, 20'h0050C, 20'hF0500, 64'd3, 1'b0, 1'b0},
    // R9 wrap of the 12-byte step
    '{4'd9, 20'hFFFF8, 32'h04004000, 32'h0000_0001, 32'h0000_0002, 64'd4, 64'h0000_0002_0000_0001, 20'h00004, 20'hEFFF8, 64'd4, 1'b0, 1'b0},
    // R6 forward branch
    '{4'd6, 20'h01000, 32'h08000010, 32'h0, 32'h0, 64'd5, 64'h10, 20'h01040, 20'h01040, 64'd5, 1'b0, 1'b1},
    // R6 branch offset equal to an escape code
    '{4'd6, 20'h20000, 32'h08004000, 32'h0, 32'h0, 64'd5, 64'hFFFF_FFFF_FFFF_C000, 20'h10000, 20'h10000, 64'd5, 1'b0, 1'b1},
    // R7 loop taken
    '{4'd7, 20'h03000, 32'h0C007FFF, 32'h0, 32'h0, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 20'h02FFC, 20'h02FFC, 64'd4, 1'b1, 1'b1},
    // R7 loop reaches zero, falls through
    '{4'd7, 20'h03000, 32'h0C007FFF, 32'h0, 32'h0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 20'h03004, 20'h02FFC, 64'd0, 1'b1, 1'b0},
    // R7 loop underflow from zero
    '{4'd7, 20'h03000, 32'h0C007FFF, 32'h0, 32'h0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 20'h02FFC, 20'h02FFC, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1},
    // R8 other opcode with escape value
    '{4'd8, 20'h00600, 32'hFC004001, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 64'd9, 64'hFFFF_FFFF_FFFF_C001, 20'h00604, 20'hF0604, 64'd9, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1 outValid", {63'd0, outValid}, 64'd0);
    chk("R1 operand", operand, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 nextIp", {44'd0, nextIp}, 64'd0);
    chk("R1 flags", {61'd0, loopWrite, taken, outValid}, 64'd0);
    chk("R1 loopOut", loopOut, 64'd0);

    for (int i = 0; i < NV; i++) begin
      curIp = VECS[i].ip;  instrWord = VECS[i].instr;
      extWord0 = VECS[i].w0; extWord1 = VECS[i].w1; loopIn = VECS[i].lin;
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      chk($sformatf("R2 valid vec%0d", i), {63'd0, outValid}, 64'd1);
      chk($sformatf("R%0d operand vec%0d", VECS[i].req, i), operand, VECS[i].expOp);
      chk($sformatf("R%0d nextIp vec%0d", VECS[i].req, i), {44'd0, nextIp}, {44'd0, VECS[i].expNext});
      chk($sformatf("R%0d target vec%0d", VECS[i].req, i), {44'd0, branchTarget}, {44'd0, VECS[i].expTgt});
      chk($sformatf("R%0d loopOut vec%0d", VECS[i].req, i), loopOut, VECS[i].expLoop);
      chk($sformatf("R%0d flags vec%0d", VECS[i].req, i), {62'd0, loopWrite, taken},
          {62'd0, VECS[i].expWe, VECS[i].expTaken});
    end

    // R2 inputs with inValid low are ignored (last result was vec 11)
    curIp = 20'h0ABC0; instrWord = 32'h0C000003; loopIn = 64'd77;
    extWord0 = 32'h1; extWord1 = 32'h2;
    @(negedge clk);
    chk("R2 valid low", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    chk("R2 operand held", operand, 64'hFFFF_FFFF_FFFF_C001);
    chk("R2 nextIp held", {44'd0, nextIp}, 64'h00604);
    chk("R2 loopOut held", loopOut, 64'd9);
    chk("R2 flags held", {62'd0, loopWrite, taken}, 64'd0);

    // R7 back-to-back loop steps: each decrements by exactly one
    curIp = 20'h04000; instrWord = 32'h0C007FFE; loopIn = 64'd3; inValid = 1'b1;
    @(negedge clk);
    chk("R7 step1 loopOut", loopOut, 64'd2);
    chk("R7 step1 nextIp", {44'd0, nextIp}, 64'h03FF8);
    loopIn = loopOut;
    @(negedge clk);
    inValid = 1'b0;
    chk("R7 step2 loopOut", loopOut, 64'd1);
    chk("R7 step2 taken", {63'd0, taken}, 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule